// File: doc/BRIEF.md
# System Watchdog Timer with Prescaler

The block is a watchdog for a system that must prove it is still alive. A reference clock is divided by one of four selectable ratios, and every divided tick lowers a down-counter. Software keeps the counter away from zero by writing a fixed key to a restart register. If the restarts stop, the counter runs out one full period later. The block then raises a timeout flag and, only when software has allowed it, drives a system-reset pulse of programmable length.

Software reaches the four registers over a simple 32-bit write/read bus with a word address. The mode and count-control registers accept a write only when the top twelve bits carry the right access key, so a stray write cannot disarm the timer. The reload value is a 12-bit field from software with a run of fixed one bits appended below it. With the default widths, a field of N gives a reload of 0xNFFF.

Top module: `sys_watchdog`

## Requirements
- R1: After reset, the mode word reads 0, the count-control word reads 0x00003FFC (field all ones, prescale select 0), the status word reads 0, and both `sysRstOut` and `timeoutFlag` are low.
- R2: A write to word address 0 (mode) takes effect only when data bits [31:20] equal 0xABC. It then sets run enable from bit 0, reset-output enable from bit 1 and pulse-length select from bits [3:2]. With any other key value the mode state is left unchanged. Reading word address 0 returns these three fields in the same bit positions.
- R3: A write to word address 1 (count control) takes effect only when data bits [31:20] equal 0x248. It then sets the prescale select from bits [1:0] and the reload field N from bits [13:2]. With any other key value the register is unchanged. Reading returns the two fields in the same positions.
- R4: A write of exactly 0x00001999 to word address 3 (restart) loads the counter with {N, FILL_BITS ones}, clears the prescaler and clears the timeout flag. Any other data written there has no effect on the counter. Reading word address 3 returns 0.
- R5: Prescale selects 0, 1, 2 and 3 divide by 8, 64, 512 and 4096. While running, the timeout flag rises exactly ratio × reload clock cycles after the restart edge.
- R6: While run enable is 0, the counter and the prescaler hold their values. Each cycle spent stopped delays the timeout by exactly one cycle.
- R7: Status bit 0 at word address 2, and the `timeoutFlag` port that mirrors it, set when the counter reaches zero. They stay set until the next valid restart.
- R8: When reset-output enable is 1 at the moment of timeout, `sysRstOut` goes high in the same cycle as the timeout flag. It stays high for 4, 8, 16 or 32 cycles for pulse select 0 to 3. When the enable is 0, a timeout sets only the flag and `sysRstOut` stays low.
- R9: Once at zero, the counter stays there until a restart. No second reset pulse follows without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 2 | Word address: 0 mode, 1 count control, 2 status, 3 restart |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| sysRstOut | output | 1 | System-reset pulse |
| timeoutFlag | output | 1 | Level timeout flag, same as status bit 0 |

## Verification
A write takes effect at the clock edge where `busWr` is sampled. A restart edge counts as cycle 0, and the flag and the reset pulse are due ratio × reload edges later. Each test therefore counts falling edges from the restart edge and samples one cycle before the due edge, expecting the old value, and again just after it, expecting the new one. The pulse is sampled on its first and last high cycle and on the first cycle after it. The hold test adds exactly the number of stopped edges to the due cycle. For the ignored-write cases, the test reads the register back, or times the flag, before it issues any further write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    REG_ZMODE = 2'd0,
    REG_CCTRL = 2'd1,
    REG_STAT  = 2'd2,
    REG_KICK  = 2'd3
  } reg_sel_e;

  // control-to-datapath strobes and configuration
  typedef struct packed {
    logic       restart;
    logic       run;
    logic       rstOutEn;
    logic [1:0] pulseSel;
    logic [1:0] preSel;
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          FIELD_W     = 12,
  parameter int          KEY_W       = 12,
  parameter logic [11:0] ZM_KEY      = 12'hABC,
  parameter logic [11:0] CC_KEY      = 12'h248,
  parameter logic [31:0] RESTART_KEY = 32'h0000_1999
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               timeoutSt,
  output wdt_strobe_t        stb,
  output logic [FIELD_W-1:0] reloadField
);
  localparam int KEY_LSB = 32 - KEY_W;

  reg_sel_e          regSel;
  logic [KEY_W-1:0]  wrKey;
  logic              zmWr, ccWr;
  logic              runEn, rstOutEn;
  logic [1:0]        pulseSel, preSel;
  logic [FIELD_W-1:0] fieldReg;

  assign regSel = reg_sel_e'(busAddr);
  assign wrKey  = busWdata[31:KEY_LSB];
  assign zmWr   = busWr && (regSel == REG_ZMODE) && (wrKey == KEY_W'(ZM_KEY));
  assign ccWr   = busWr && (regSel == REG_CCTRL) && (wrKey == KEY_W'(CC_KEY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      rstOutEn <= 1'b0;
      pulseSel <= 2'd0;
    end else if (zmWr) begin
      runEn    <= busWdata[0];
      rstOutEn <= busWdata[1];
      pulseSel <= busWdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSel   <= 2'd0;
      fieldReg <= '1;
    end else if (ccWr) begin
      preSel   <= busWdata[1:0];
      fieldReg <= busWdata[2 +: FIELD_W];
    end
  end

  always_comb begin
    stb.restart  = busWr && (regSel == REG_KICK) && (busWdata == RESTART_KEY);
    stb.run      = runEn;
    stb.rstOutEn = rstOutEn;
    stb.pulseSel = pulseSel;
    stb.preSel   = preSel;
  end
  assign reloadField = fieldReg;

  always_comb begin
    busRdata = '0;
    unique case (regSel)
      REG_ZMODE: busRdata[3:0] = {pulseSel, rstOutEn, runEn};
      REG_CCTRL: begin
        busRdata[1:0]          = preSel;
        busRdata[2 +: FIELD_W] = fieldReg;
      end
      REG_STAT:  busRdata[0] = timeoutSt;
      default:   busRdata = '0;
    endcase
  end

  // R2: a mode write with a wrong key leaves the mode state alone
  p_zm_key_guard_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0 && busWdata[31:KEY_LSB] != KEY_W'(ZM_KEY))
      |=> $stable({runEn, rstOutEn, pulseSel}));

  // R3: a count-control write with a wrong key leaves the register alone
  p_cc_key_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1 && busWdata[31:KEY_LSB] != KEY_W'(CC_KEY))
      |=> $stable({preSel, fieldReg}));

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int FIELD_W   = 12,
  parameter int FILL_BITS = 12,
  parameter int PRE_BASE  = 3,
  parameter int PRE_STEP  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdt_strobe_t        stb,
  input  logic [FIELD_W-1:0] reloadField,
  output logic               timeoutSt,
  output logic               sysRstOut
);
  localparam int COUNT_W = FIELD_W + FILL_BITS;
  localparam int PRE_W   = PRE_BASE + 3 * PRE_STEP;
  localparam int PULSE_W = 6;

  logic [COUNT_W-1:0] count, reloadVal;
  logic [PRE_W-1:0]   preCnt, preLimit;
  logic [PULSE_W-1:0] pulseCnt, pulseLen;
  logic               tick, lastTick;

  assign reloadVal = {reloadField, {FILL_BITS{1'b1}}};

  always_comb
    preLimit = PRE_W'((32'd1 << (PRE_BASE + PRE_STEP * int'(stb.preSel))) - 32'd1);

  assign tick     = stb.run && (count != '0) && (preCnt >= preLimit);
  assign lastTick = tick && (count == COUNT_W'(1));
  assign pulseLen = PULSE_W'(4) << stb.pulseSel;

  // prescaler and down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      count     <= '1;
      timeoutSt <= 1'b0;
    end else if (stb.restart) begin
      preCnt    <= '0;
      count     <= reloadVal;
      timeoutSt <= 1'b0;
    end else if (stb.run && count != '0) begin
      if (tick) begin
        preCnt <= '0;
        count  <= count - COUNT_W'(1);
        if (lastTick) timeoutSt <= 1'b1;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // reset pulse stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pulseCnt <= '0;
    else if (lastTick && stb.rstOutEn) pulseCnt <= pulseLen;
    else if (pulseCnt != '0)           pulseCnt <= pulseCnt - PULSE_W'(1);
  end
  assign sysRstOut = (pulseCnt != '0);

  // R4: a valid restart loads {N, ones}
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> count == {$past(reloadField), {FILL_BITS{1'b1}}});

  // R6: a stopped timer holds its count
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.restart && !stb.run) |=> $stable(count) && $stable(preCnt));

  // R7: the flag stays until a restart
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutSt && !stb.restart) |=> timeoutSt);

  // R7: the flag only stands with an exhausted counter
  p_flag_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutSt |-> count == '0);

  // R9: the counter stays at zero until restarted
  p_stop_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !stb.restart) |=> count == '0);

  // R8: a pulse only starts while the reset output is enabled
  p_rst_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> $past(stb.rstOutEn) && timeoutSt);

endmodule

// File: rtl/sys_watchdog.sv
module sys_watchdog
  import wdt_pkg::*;
#(
  parameter int FIELD_W   = 12,
  parameter int FILL_BITS = 12,
  parameter int PRE_BASE  = 3,
  parameter int PRE_STEP  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sysRstOut,
  output logic        timeoutFlag
);
  wdt_strobe_t        stb;
  logic [FIELD_W-1:0] reloadField;
  logic               timeoutSt;

  wdt_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .timeoutSt  (timeoutSt),
    .stb        (stb),
    .reloadField(reloadField)
  );

  wdt_datapath #(
    .FIELD_W  (FIELD_W),
    .FILL_BITS(FILL_BITS),
    .PRE_BASE (PRE_BASE),
    .PRE_STEP (PRE_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reloadField(reloadField),
    .timeoutSt  (timeoutSt),
    .sysRstOut  (sysRstOut)
  );

  assign timeoutFlag = timeoutSt;

endmodule

// File: tb/sys_watchdog_test.sv
module sys_watchdog_test;
  localparam int FILL = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sysRstOut, timeoutFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sys_watchdog #(.FILL_BITS(FILL)) uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .sysRstOut(sysRstOut), .timeoutFlag(timeoutFlag)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; takes effect at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitM(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setZm(input bit run, input bit en, input logic [1:0] ps);
    wr(2'd0, 32'hABC0_0000 | (32'(ps) << 2) | (32'(en) << 1) | 32'(run));
  endtask

  task automatic setCc(input logic [1:0] sel, input logic [11:0] n);
    wr(2'd1, 32'h2480_0000 | (32'(n) << 2) | 32'(sel));
  endtask

  task automatic kick();
    wr(2'd3, 32'h0000_1999);
  endtask

  function automatic int periodOf(input int sel, input int n);
    return (1 << (3 + 3 * sel)) * ((n << FILL) | ((1 << FILL) - 1));
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 mode reset", d, 32'h0);
    rd(2'd1, d); check("R1 count-control reset", d, 32'h0000_3FFC);
    rd(2'd2, d); check("R1 status reset", d, 32'h0);
    rd(2'd3, d); check("R4 restart reads zero", d, 32'h0);
    check("R1 outputs low", {30'd0, sysRstOut, timeoutFlag}, 32'h0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(2'd0, 32'h1230_0003);
    rd(2'd0, d); check("R2 wrong key ignored", d, 32'h0);
    wr(2'd0, 32'hABC0_000E);
    rd(2'd0, d); check("R2 keyed write", d, 32'h0000_000E);
    wr(2'd1, 32'h2490_0001);
    rd(2'd1, d); check("R3 wrong key ignored", d, 32'h0000_3FFC);
    wr(2'd1, 32'h2480_000B);
    rd(2'd1, d); check("R3 keyed write", d, 32'h0000_000B);
    setZm(1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_period(input int sel, input int n);
    int t;
    logic [31:0] d;
    t = periodOf(sel, n);
    setCc(2'(sel), 12'(n));
    setZm(1'b1, 1'b0, 2'd0);
    kick();
    rd(2'd2, d); check("R7 restart clears status", d, 32'h0);
    waitM(t - 1);
    check("R5 no timeout one cycle early", {31'd0, timeoutFlag}, 32'h0);
    waitM(1);
    check("R5 timeout on due cycle", {31'd0, timeoutFlag}, 32'h1);
    rd(2'd2, d); check("R7 status bit set", d, 32'h1);
  endtask

  task automatic t_bad_restart();
    int t;
    t = periodOf(0, 2);
    setCc(2'd0, 12'd2);
    setZm(1'b1, 1'b0, 2'd0);
    kick();
    waitM(99);
    wr(2'd3, 32'h0000_1998);
    waitM(t - 1 - 100);
    check("R4 wrong restart value: no early flag", {31'd0, timeoutFlag}, 32'h0);
    waitM(1);
    check("R4 wrong restart value did not reload", {31'd0, timeoutFlag}, 32'h1);
  endtask

  task automatic t_hold();
    int t;
    t = periodOf(0, 2);
    setCc(2'd0, 12'd2);
    setZm(1'b1, 1'b0, 2'd0);
    kick();
    waitM(99);
    setZm(1'b0, 1'b0, 2'd0);   // effective at edge 100
    waitM(49);
    setZm(1'b1, 1'b0, 2'd0);   // effective at edge 150
    waitM(t + 50 - 1 - 150);
    check("R6 stop delays timeout", {31'd0, timeoutFlag}, 32'h0);
    waitM(1);
    check("R6 timeout after hold", {31'd0, timeoutFlag}, 32'h1);
  endtask

  task automatic t_pulse(input int ps);
    int t, len;
    t   = periodOf(0, 0);
    len = 4 << ps;
    setCc(2'd0, 12'd0);
    setZm(1'b1, 1'b1, 2'(ps));
    kick();
    waitM(t - 1);
    check("R8 reset low before timeout", {31'd0, sysRstOut}, 32'h0);
    waitM(1);
    check("R8 reset rises with timeout", {31'd0, sysRstOut}, 32'h1);
    waitM(len - 1);
    check("R8 reset high on last cycle", {31'd0, sysRstOut}, 32'h1);
    waitM(1);
    check("R8 reset low after pulse", {31'd0, sysRstOut}, 32'h0);
    waitM(3 * t);
    check("R9 no second pulse", {31'd0, sysRstOut}, 32'h0);
    check("R9 flag still held at zero", {31'd0, timeoutFlag}, 32'h1);
  endtask

  task automatic t_disabled();
    int t;
    bit seen;
    t = periodOf(0, 0);
    seen = 1'b0;
    setCc(2'd0, 12'd0);
    setZm(1'b1, 1'b0, 2'd3);
    kick();
    for (int i = 0; i < t + 40; i++) begin
      @(negedge clk);
      if (sysRstOut) seen = 1'b1;
    end
    check("R8 disabled output stays low", {31'd0, seen}, 32'h0);
    check("R8 disabled still flags", {31'd0, timeoutFlag}, 32'h1);
  endtask

  initial begin
    waitM(3);
    rstN = 1'b1;
    waitM(1);
    t_reset();
    t_keys();
    t_period(0, 2);
    t_period(1, 0);
    t_period(2, 0);
    t_period(3, 0);
    t_bad_restart();
    t_hold();
    t_pulse(0);
    t_pulse(3);
    t_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule